// File: doc/BRIEF.md
# Double-Binary Circular Convolutional Encoder

This block is one constituent encoder of a turbo code. It takes one couple of data bits (A, B) per accepted handshake and feeds both into an 8-state recursive systematic trellis. For each couple it emits the couple unchanged, one parity bit Y, and a flag that marks whether Y survives puncturing at the selected code rate.

The code is circular: the encoder must finish each frame in the same state it started from. The state that makes this true depends on the data. The block therefore runs in two passes. The first is a pre-pass that starts from the all-zero state and produces no output. At its last couple, the block derives the circulation state from the final state and the frame length and holds that state. The second pass starts from the held state and produces the coded stream. When the frame length is a multiple of 7, no circulation state exists, and the block raises an error flag.

The upstream source presents the couples in the order to be coded, either natural or interleaved. The same puncturing applies to both orders. Packing the output bits into channel symbols is done downstream.

Top module: `dbcc_encoder`

## Requirements
- R1: The state is a 3-bit register {s1,s2,s3}. For each accepted couple the feedback is f = A^B^s1^s3, and the next state is s1=f, s2=s1^B, s3=s2^B. This is the feedback polynomial 1+D+D^3, with A entering at the first tap only and B entering at the first, second and third taps.
- R2: The parity bit is Y = f^s2^s3 (polynomial 1+D^2+D^3), computed from the state before the couple is applied.
- R3: The register after an accepted encoding couple drives out_valid high one cycle later, with out_a and out_b equal to the accepted A and B.
- R4: A phase counter runs from 0 to 5 and wraps. It restarts at 0 on the couple that carries in_sof. The value of out_keep depends on cfg_rate:
  - cfg_rate 0 (rate 1/2) and cfg_rate 3: every phase keeps.
  - cfg_rate 1 (rate 2/3): phases 0, 2 and 4 keep.
  - cfg_rate 2 (rate 3/4): phases 0 and 3 keep.
- R5: A couple accepted with cfg_prepass high produces no output. A pre-pass frame starts from state 0 at in_sof. At the couple numbered cfg_len-1, the block stores the circulation state C. C is the state from which encoding the same frame ends back in C.
- R6: A couple accepted with cfg_prepass low and in_sof high starts from the stored circulation state. The stored state is kept until the next pre-pass ends.
- R7: When a pre-pass ends, circ_err is set to (cfg_len mod 7 == 0). In that case the stored circulation state is 0.
- R8: in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, all outputs hold their values.
- R9: After reset, out_valid and circ_err are low, and the stored circulation state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | LEN_W | Frame length in couples |
| cfg_rate | input | 2 | Code rate select (0: 1/2, 1: 2/3, 2: 3/4, 3: all kept) |
| cfg_prepass | input | 1 | High: the accepted couple belongs to a pre-pass from the zero state |
| in_valid | input | 1 | Couple present |
| in_ready | output | 1 | Couple can be accepted |
| in_sof | input | 1 | First couple of a frame |
| in_a | input | 1 | First bit of the couple |
| in_b | input | 1 | Second bit of the couple |
| out_valid | output | 1 | Coded couple present |
| out_ready | input | 1 | Downstream accepts the coded couple |
| out_a | output | 1 | Systematic bit A |
| out_b | output | 1 | Systematic bit B |
| out_y | output | 1 | Parity bit |
| out_keep | output | 1 | Parity bit survives puncturing |
| circ_err | output | 1 | Last pre-pass had a length that is a multiple of 7 |

## Verification
The critical collision is the last couple of a pre-pass followed, in the very next cycle, by the in_sof couple of the encoding pass. In that cycle the circulation state written by one edge must already be the start state read for the following couple. The bench drives the two passes back to back. It also inserts random input gaps and random out_ready stalls, so the hand-off sometimes lands on a stalled output register and sometimes on a free one. Every coded couple is compared with a bench model. That model finds the circulation state by trying all eight start states and keeping the one that ends where it began.

// File: rtl/dbcc_pkg.sv
`timescale 1ns/1ps
package dbcc_pkg;

    // State bits: [2] = s1 (first stage), [1] = s2, [0] = s3
    typedef logic [2:0] trel_t;

    typedef enum logic [1:0] {
        RATE_HALF     = 2'd0,
        RATE_TWO_3RD  = 2'd1,
        RATE_THREE_QT = 2'd2,
        RATE_ALL      = 2'd3
    } rate_e;

    localparam logic [2:0] PUNC_LAST = 3'd5;
    localparam int         ZERO_CYC  = 7;

    // One step of the trellis with both inputs at zero
    function automatic trel_t free_step(trel_t s);
        return {s[2] ^ s[0], s[2], s[1]};
    endfunction

endpackage

// File: rtl/dbcc_trellis.sv
`timescale 1ns/1ps
module dbcc_trellis
    import dbcc_pkg::*;
(
    input  trel_t st_i,
    input  logic  a_i,
    input  logic  b_i,
    output trel_t nxt_o,
    output logic  par_o
);
    logic fb;

    always_comb begin
        fb    = a_i ^ b_i ^ st_i[2] ^ st_i[0];
        nxt_o = {fb, st_i[2] ^ b_i, st_i[1] ^ b_i};
        par_o = fb ^ st_i[1] ^ st_i[0];
    end
endmodule

// File: rtl/dbcc_circ_solver.sv
`timescale 1ns/1ps
module dbcc_circ_solver
    import dbcc_pkg::*;
(
    input  trel_t      fin_i,
    input  logic [2:0] nmod_i,
    output trel_t      circ_o
);
    // Find C with C ^ G^n(C) == final state of the zero-start pass
    trel_t walk;

    always_comb begin
        circ_o = '0;
        walk   = '0;
        for (int c = 0; c < 8; c++) begin
            walk = c[2:0];
            for (int k = 0; k < ZERO_CYC - 1; k++) begin
                if (k < int'(nmod_i)) walk = free_step(walk);
            end
            if (nmod_i != 3'd0 && (walk ^ trel_t'(c[2:0])) == fin_i)
                circ_o = c[2:0];
        end
    end
endmodule

// File: rtl/dbcc_puncture.sv
`timescale 1ns/1ps
module dbcc_puncture
    import dbcc_pkg::*;
(
    input  logic [1:0] rate_i,
    input  logic [2:0] phase_i,
    output logic       keep_o
);
    always_comb begin
        case (rate_e'(rate_i))
            RATE_TWO_3RD:  keep_o = ~phase_i[0];
            RATE_THREE_QT: keep_o = (phase_i == 3'd0) || (phase_i == 3'd3);
            default:       keep_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbcc_encoder.sv
`timescale 1ns/1ps
module dbcc_encoder
    import dbcc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_rate,
    input  logic             cfg_prepass,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic             in_a,
    input  logic             in_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_a,
    output logic             out_b,
    output logic             out_y,
    output logic             out_keep,
    output logic             circ_err
);
    typedef struct packed {
        trel_t            st;
        logic [LEN_W-1:0] cnt;
        logic [2:0]       ph;
        trel_t            circ;
        logic             err;
        logic             ov;
        logic             oa;
        logic             ob;
        logic             oy;
        logic             ok;
    } regs_t;

    regs_t            q, d;
    trel_t            cur_st, nxt_st, circ_sol;
    logic             par, keep, accept;
    logic [LEN_W-1:0] nrem, cur_cnt;
    logic [2:0]       nmod, cur_ph;

    assign nrem = cfg_len % LEN_W'(ZERO_CYC);
    assign nmod = nrem[2:0];

    dbcc_trellis u_trel (
        .st_i  (cur_st),
        .a_i   (in_a),
        .b_i   (in_b),
        .nxt_o (nxt_st),
        .par_o (par)
    );

    dbcc_circ_solver u_circ (
        .fin_i  (nxt_st),
        .nmod_i (nmod),
        .circ_o (circ_sol)
    );

    dbcc_puncture u_punc (
        .rate_i  (cfg_rate),
        .phase_i (cur_ph),
        .keep_o  (keep)
    );

    assign in_ready  = !q.ov || out_ready;
    assign out_valid = q.ov;
    assign out_a     = q.oa;
    assign out_b     = q.ob;
    assign out_y     = q.oy;
    assign out_keep  = q.ok;
    assign circ_err  = q.err;

    always_comb begin
        accept  = in_valid && in_ready;
        cur_st  = in_sof ? (cfg_prepass ? trel_t'(0) : q.circ) : q.st;
        cur_cnt = in_sof ? '0 : q.cnt;
        cur_ph  = in_sof ? 3'd0 : q.ph;
        d = q;
        if (out_ready) d.ov = 1'b0;
        if (accept) begin
            d.st  = nxt_st;
            d.cnt = cur_cnt + 1'b1;
            d.ph  = (cur_ph == PUNC_LAST) ? 3'd0 : 3'(cur_ph + 3'd1);
            if (cfg_prepass) begin
                if (cur_cnt == cfg_len - 1'b1) begin
                    d.circ = circ_sol;
                    d.err  = (nmod == 3'd0);
                end
            end else begin
                d.ov = 1'b1;
                d.oa = in_a;
                d.ob = in_b;
                d.oy = par;
                d.ok = keep;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dbcc_encoder_chk.sv
`timescale 1ns/1ps
module dbcc_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_rate,
    input logic       cfg_prepass,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_a,
    input logic       in_b,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_a,
    input logic       out_b,
    input logic       out_y,
    input logic       out_keep
);
    // R8
    ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable({out_a, out_b, out_y, out_keep}));

    // R3
    sys_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !cfg_prepass |=>
            out_valid && out_a == $past(in_a) && out_b == $past(in_b));

    // R5
    prepass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_prepass |=> !out_valid);

    // R4
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !cfg_prepass && (cfg_rate[1] == cfg_rate[0]) |=> out_keep);
endmodule

bind dbcc_encoder dbcc_encoder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rate    (cfg_rate),
    .cfg_prepass (cfg_prepass),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_a       (out_a),
    .out_b       (out_b),
    .out_y       (out_y),
    .out_keep    (out_keep)
);

// File: tb/dbcc_encoder_tb_top.sv
`timescale 1ns/1ps
module dbcc_encoder_tb_top;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] cfg_len = '0;
    logic [1:0]    cfg_rate = '0;
    logic          cfg_prepass = 1'b0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_a = 1'b0, in_b = 1'b0;
    logic          in_ready, out_valid, out_a, out_b, out_y, out_keep, circ_err;
    logic          out_ready = 1'b0;

    always #4 clk = ~clk;

    dbcc_encoder #(.LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_rate(cfg_rate),
        .cfg_prepass(cfg_prepass), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_a(out_a), .out_b(out_b), .out_y(out_y),
        .out_keep(out_keep), .circ_err(circ_err)
    );

    int   checks = 0, errors = 0;
    logic ea [0:1023];
    logic eb [0:1023];
    logic ey [0:1023];
    logic ek [0:1023];
    int   wr = 0, rd = 0;
    logic da [0:63];
    logic db [0:63];
    logic [2:0] held_circ = 3'd0;
    bit   exp_err = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Returns {next_state, y}
    function automatic logic [3:0] ref_step(logic [2:0] s, logic a, logic b);
        logic r1, r2, r3, fb;
        r1 = s[2]; r2 = s[1]; r3 = s[0];
        fb = a ^ b ^ r1 ^ r3;
        return {fb, r1 ^ b, r2 ^ b, fb ^ r2 ^ r3};
    endfunction

    function automatic logic [2:0] run_from(logic [2:0] s0, int n);
        logic [2:0] s = s0;
        for (int i = 0; i < n; i++) s = ref_step(s, da[i], db[i])[3:1];
        return s;
    endfunction

    function automatic logic keep_of(int rate, int ph);
        logic [5:0] m;
        case (rate)
            1:       m = 6'b101010;
            2:       m = 6'b100100;
            default: m = 6'b111111;
        endcase
        return m[5 - ph];
    endfunction

    // Output monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && out_valid && out_ready) begin
                if (rd == wr) begin
                    chk(1'b0, "R5", "unexpected output couple", 1, 0);
                end else begin
                    chk(out_a == ea[rd] && out_b == eb[rd], "R3", "systematic couple",
                        {out_a, out_b}, {ea[rd], eb[rd]});
                    // R1 state sequence shows up through parity
                    chk(out_y == ey[rd], "R2", "parity bit", out_y, ey[rd]);
                    chk(out_keep == ek[rd], "R4", "keep flag", out_keep, ek[rd]);
                    rd++;
                end
            end
        end
    end

    task automatic send(logic sof, logic a, logic b, logic pre);
        bit done = 1'b0;
        while (!done) begin
            @(negedge clk);
            out_ready   = ($urandom % 10) < 7;
            in_valid    = 1'b1;
            in_sof      = sof;
            in_a        = a;
            in_b        = b;
            cfg_prepass = pre;
            #1;
            if (in_ready) done = 1'b1;
        end
        @(posedge clk);
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(string req);
        int w = 0;
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        while (rd != wr && w < 200) begin
            @(negedge clk);
            w++;
        end
        chk(rd == wr, req, "coded couples outstanding", wr - rd, 0);
    endtask

    task automatic frame(int n, int rate, bit pre, bit enc, bit fresh);
        logic [3:0] r;
        logic [2:0] st;
        if (fresh) begin
            for (int i = 0; i < n; i++) begin
                da[i] = $urandom % 2;
                db[i] = $urandom % 2;
            end
        end
        @(negedge clk);
        cfg_len  = LW'(n);
        cfg_rate = rate[1:0];
        if (pre) begin
            for (int i = 0; i < n; i++) send(i == 0, da[i], db[i], 1'b1);
            exp_err   = (n % 7) == 0;
            held_circ = 3'd0;
            if (!exp_err) begin
                for (int c = 0; c < 8; c++)
                    if (run_from(c[2:0], n) == c[2:0]) held_circ = c[2:0];
            end
        end
        if (enc) begin
            st = held_circ;
            for (int i = 0; i < n; i++) begin
                r = ref_step(st, da[i], db[i]);
                ea[wr] = da[i]; eb[wr] = db[i]; ey[wr] = r[0];
                ek[wr] = keep_of(rate, i % 6);
                wr++;
                st = r[3:1];
                if (($urandom % 6) == 0) gap();
                send(i == 0, da[i], db[i], 1'b0);
            end
        end
        drain("R8");
        chk(circ_err == exp_err, "R7", "error flag", circ_err, exp_err);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL R8 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
        chk(circ_err == 1'b0, "R9", "circ_err in reset", circ_err, 0);
        rst_n = 1'b1;
        // R9: encoding without any pre-pass starts from state 0
        frame(8, 0, 1'b0, 1'b1, 1'b1);
        // R5 R6: pre-pass then encode, back to back
        frame(8, 0, 1'b1, 1'b1, 1'b1);
        frame(12, 1, 1'b1, 1'b1, 1'b1);
        frame(24, 2, 1'b1, 1'b1, 1'b1);
        // R6: stored state reused by an encode-only frame, rate code 3
        frame(24, 3, 1'b0, 1'b1, 1'b0);
        // R5: lone pre-pass emits nothing (monitor flags any output)
        frame(20, 1, 1'b1, 1'b0, 1'b1);
        frame(20, 1, 1'b0, 1'b1, 1'b0);
        // R7: length multiple of 7, then a valid length clears the flag
        frame(28, 2, 1'b1, 1'b1, 1'b1);
        frame(16, 1, 1'b1, 1'b1, 1'b1);
        frame(56, 0, 1'b1, 1'b1, 1'b1);
        // R1 R2 R4: random lengths and rates
        for (int f = 0; f < 10; f++) begin
            frame(4 * (1 + ($urandom % 16)), $urandom % 4, 1'b1, 1'b1, 1'b1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule